// File: doc/BRIEF.md
# Completion Ring Posting Engine

The engine owns one circular completion ring that lives in host memory. Finished-command records arrive on a valid/ready input. Each record holds a command identifier, a submission queue id, that submission queue's current head value and a 15-bit status code. The records wait in a small input FIFO until the ring has room. The engine then builds a 16-byte completion entry that carries a phase tag and issues it as a single memory write request at the current tail slot. It tracks the tail, the head that the host reports back and the phase bit. When a run of postings ends, it raises a one-cycle interrupt request.

A create strobe programs the queue. It latches the base address, the zero-based ring size and the interrupt enable, and it resets the tail and head to 0 and the phase to 1. The host returns slots with a head-update strobe. The write port is a plain valid/ready request. Bus handling, interrupt message encoding and arbitration among several rings are left to neighbouring blocks.

The sequencer has three states. `ST_WAIT` looks for work. `ST_POST` holds a write request until it is accepted. `ST_RAISE` ends a posting run. The transitions are:
- *start* (`ST_WAIT`→`ST_POST`): the FIFO holds a record and the ring is not full.
- *run-end* (`ST_WAIT`→`ST_RAISE`): at least one entry was posted since the last run-end, and no further posting is possible.
- *accepted* (`ST_POST`→`ST_WAIT`): the write is accepted.
- *notified* (`ST_RAISE`→`ST_WAIT`): always, after one cycle.
- *idle* (`ST_WAIT` stays): neither start nor run-end applies.
- *hold* (`ST_POST` stays): the write is not yet accepted.

A create strobe forces `ST_WAIT` from any state.

Top module: `cq_post_engine`

## Requirements
- R1: After reset, `wr_valid_o` and `irq_o` are low and `rec_ready_o` is high. Before the first create strobe, no entry is posted. A create strobe sets tail = 0, head = 0 and phase = 1.
- R2: The write address is the latched base plus tail × 2^ENTRY_EXP bytes.
- R3: The 128-bit entry is laid out as follows:
  - bits [127:113]: the status code
  - bit [112]: the current phase
  - bits [111:96]: the command identifier
  - bits [95:80]: the submission queue id
  - bits [79:64]: the submission queue head
  - bits [63:0]: zero
  
  The 16-bit status field is therefore code << 1 OR phase.
- R4: The ring size is the programmed zero-based size plus one. The tail moves up by one per accepted write. When it would reach the size it returns to 0, and the phase inverts.
- R5: The ring is full when (tail+1) mod size equals head. While it is full, no write request starts. Pending records stay queued and post in arrival order once room returns.
- R6: A head update takes effect in the cycle after its strobe. A value greater than or equal to the ring size is ignored.
- R7: `rec_ready_o` is low while FIFO_DEPTH records are pending.
- R8: While `wr_valid_o` is high and `wr_ready_i` low, the request stays valid and its address and data stay unchanged.
- R9: A posting run that wrote at least one entry ends with a one-cycle `irq_o` pulse, and only when the interrupt enable was latched high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| create_i | input | 1 | Queue creation strobe; latches configuration |
| cfg_base_i | input | ADDR_W | Ring base address in host memory |
| cfg_qsize_i | input | 16 | Zero-based ring size |
| cfg_irq_en_i | input | 1 | Interrupt enable for this ring |
| rec_valid_i | input | 1 | Completion record valid |
| rec_ready_o | output | 1 | Record FIFO can accept |
| rec_cid_i | input | 16 | Command identifier |
| rec_sqid_i | input | 16 | Submission queue id |
| rec_sqhd_i | input | 16 | Submission queue head value |
| rec_code_i | input | 15 | Status code |
| head_wr_i | input | 1 | Host head update strobe |
| head_val_i | input | 16 | New head value |
| wr_valid_o | output | 1 | Memory write request valid |
| wr_ready_i | input | 1 | Memory write request accepted |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | 128 | Completion entry |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The bench builds the engine with FIFO_DEPTH = 2 and ENTRY_EXP = 5. With the shallow FIFO, two records stalled behind a full ring drop `rec_ready_o` at once. The 32-byte stride makes the shift on the tail distinct from the default 16-byte layout. Ring sizes of 4 and 2 are programmed at run time, so the tail wrap, the phase inversion and the full stall each occur within a handful of postings. Out-of-range head values are then shown to leave a stalled ring stalled.

// File: rtl/cqp_pkg.sv
package cqp_pkg;
    localparam int ID_W    = 16;
    localparam int CODE_W  = 15;
    localparam int ENTRY_W = 128;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_POST  = 2'd1,
        ST_RAISE = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [ID_W-1:0]   cid;
        logic [ID_W-1:0]   sqid;
        logic [ID_W-1:0]   sqhd;
    } done_rec_t;

    localparam int REC_W = $bits(done_rec_t);
endpackage

// File: rtl/cqp_fifo.sv
module cqp_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] dout_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             do_push, do_pop;

    assign empty_o = (count_q == '0);
    assign full_o  = (count_q == CNT_W'(DEPTH));
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign dout_o  = mem_q[rd_ptr_q];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= bump(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
            if (do_push && !do_pop)      count_q <= count_q + 1'b1;
            else if (do_pop && !do_push) count_q <= count_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_ptr_q] <= din_i;
    end
endmodule

// File: rtl/cqp_ring.sv
module cqp_ring #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             create_i,
    input  logic [PTR_W-1:0] qsize_m1_i,
    input  logic             advance_i,
    input  logic             head_wr_i,
    input  logic [PTR_W-1:0] head_val_i,
    output logic [PTR_W-1:0] tail_o,
    output logic [PTR_W-1:0] head_o,
    output logic [PTR_W-1:0] size_m1_o,
    output logic             phase_o,
    output logic             full_o
);
    logic [PTR_W-1:0] size_m1_q, tail_q, head_q, tail_nxt;
    logic             phase_q, tail_last;

    assign tail_last = (tail_q == size_m1_q);
    assign tail_nxt  = tail_last ? '0 : tail_q + 1'b1;
    assign full_o    = (tail_nxt == head_q);
    assign tail_o    = tail_q;
    assign head_o    = head_q;
    assign size_m1_o = size_m1_q;
    assign phase_o   = phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_m1_q <= '0;
            tail_q    <= '0;
            head_q    <= '0;
            phase_q   <= 1'b1;
        end else if (create_i) begin
            size_m1_q <= qsize_m1_i;
            tail_q    <= '0;
            head_q    <= '0;
            phase_q   <= 1'b1;
        end else begin
            if (advance_i) begin
                tail_q <= tail_nxt;
                if (tail_last) phase_q <= ~phase_q;
            end
            if (head_wr_i && (head_val_i <= size_m1_q)) head_q <= head_val_i;
        end
    end
endmodule

// File: rtl/cq_post_engine.sv
module cq_post_engine #(
    parameter int ADDR_W     = 64,
    parameter int FIFO_DEPTH = 4,
    parameter int ENTRY_EXP  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       create_i,
    input  logic [ADDR_W-1:0]          cfg_base_i,
    input  logic [15:0]                cfg_qsize_i,
    input  logic                       cfg_irq_en_i,
    input  logic                       rec_valid_i,
    output logic                       rec_ready_o,
    input  logic [15:0]                rec_cid_i,
    input  logic [15:0]                rec_sqid_i,
    input  logic [15:0]                rec_sqhd_i,
    input  logic [14:0]                rec_code_i,
    input  logic                       head_wr_i,
    input  logic [15:0]                head_val_i,
    output logic                       wr_valid_o,
    input  logic                       wr_ready_i,
    output logic [ADDR_W-1:0]          wr_addr_o,
    output logic [cqp_pkg::ENTRY_W-1:0] wr_data_o,
    output logic                       irq_o
);
    import cqp_pkg::*;

    localparam int PTR_W = ID_W;

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] base_q;
    logic              irq_en_q;
    logic              posted_q;

    done_rec_t         in_rec, head_rec;
    logic [REC_W-1:0]  head_bits;
    logic              fifo_empty, fifo_full, pop;
    logic [PTR_W-1:0]  tail, head, size_m1;
    logic              phase, ring_full, advance;

    assign in_rec = '{code: rec_code_i, cid: rec_cid_i,
                      sqid: rec_sqid_i, sqhd: rec_sqhd_i};
    assign rec_ready_o = !fifo_full;

    cqp_fifo #(.WIDTH(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (rec_valid_i),
        .din_i   (in_rec),
        .pop_i   (pop),
        .dout_o  (head_bits),
        .empty_o (fifo_empty),
        .full_o  (fifo_full)
    );
    assign head_rec = done_rec_t'(head_bits);

    cqp_ring #(.PTR_W(PTR_W)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .create_i   (create_i),
        .qsize_m1_i (cfg_qsize_i),
        .advance_i  (advance),
        .head_wr_i  (head_wr_i),
        .head_val_i (head_val_i),
        .tail_o     (tail),
        .head_o     (head),
        .size_m1_o  (size_m1),
        .phase_o    (phase),
        .full_o     (ring_full)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (!fifo_empty && !ring_full) state_d = ST_POST;   // start
                else if (posted_q)             state_d = ST_RAISE;  // run-end
            end
            ST_POST:  if (wr_ready_i) state_d = ST_WAIT;           // accepted
            ST_RAISE: state_d = ST_WAIT;                            // notified
            default:  state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || create_i) state_q <= ST_WAIT;
        else                    state_q <= state_d;
    end

    // outputs of the sequencer
    always_comb begin
        wr_valid_o = 1'b0;
        advance    = 1'b0;
        irq_o      = 1'b0;
        unique case (state_q)
            ST_WAIT:  ;
            ST_POST: begin
                wr_valid_o = 1'b1;
                advance    = wr_ready_i;
            end
            ST_RAISE: irq_o = irq_en_q;
            default:  ;
        endcase
    end
    assign pop = advance;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            irq_en_q <= 1'b0;
            posted_q <= 1'b0;
        end else if (create_i) begin
            base_q   <= cfg_base_i;
            irq_en_q <= cfg_irq_en_i;
            posted_q <= 1'b0;
        end else if (advance) begin
            posted_q <= 1'b1;
        end else if (state_q == ST_RAISE) begin
            posted_q <= 1'b0;
        end
    end

    assign wr_addr_o = base_q + (ADDR_W'(tail) << ENTRY_EXP);
    assign wr_data_o = {head_rec.code, phase, head_rec.cid, head_rec.sqid,
                        head_rec.sqhd, 64'h0};
endmodule

// File: rtl/cqp_checker.sv
module cqp_checker #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              create_i,
    input logic              wr_valid_o,
    input logic              wr_ready_i,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [127:0]      wr_data_o,
    input logic              irq_o,
    input logic              irq_en_q,
    input logic              ring_full,
    input logic              advance,
    input logic              phase,
    input logic [15:0]       tail,
    input logic [15:0]       head,
    input logic [15:0]       size_m1
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n || create_i)
        wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)); // R8

    AST_NO_START_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid_o) |-> !$past(ring_full)); // R5

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n || create_i)
        advance && (tail == size_m1) |=> (phase != $past(phase)) && (tail == 16'd0)); // R4

    AST_TAIL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tail <= size_m1); // R4

    AST_HEAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        head <= size_m1); // R6

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R9

    AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_en_q); // R9
endmodule

bind cq_post_engine cqp_checker #(.ADDR_W(ADDR_W)) u_cqp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .create_i   (create_i),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .irq_o      (irq_o),
    .irq_en_q   (irq_en_q),
    .ring_full  (ring_full),
    .advance    (advance),
    .phase      (phase),
    .tail       (tail),
    .head       (head),
    .size_m1    (size_m1)
);

// File: tb/test_cq_post_engine.sv
`timescale 1ns/1ps
module test_cq_post_engine;
    localparam int ADDR_W = 64;
    localparam int DEPTH  = 2;
    localparam int EXP    = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              create_i = 1'b0;
    logic [ADDR_W-1:0] cfg_base_i = '0;
    logic [15:0]       cfg_qsize_i = '0;
    logic              cfg_irq_en_i = 1'b0;
    logic              rec_valid_i = 1'b0;
    logic              rec_ready_o;
    logic [15:0]       rec_cid_i = '0, rec_sqid_i = '0, rec_sqhd_i = '0;
    logic [14:0]       rec_code_i = '0;
    logic              head_wr_i = 1'b0;
    logic [15:0]       head_val_i = '0;
    logic              wr_valid_o;
    logic              wr_ready_i = 1'b1;
    logic [ADDR_W-1:0] wr_addr_o;
    logic [127:0]      wr_data_o;
    logic              irq_o;

    always #2.5 clk = ~clk;

    cq_post_engine #(.ADDR_W(ADDR_W), .FIFO_DEPTH(DEPTH), .ENTRY_EXP(EXP)) i_cq_post_engine (
        .clk(clk), .rst_n(rst_n), .create_i(create_i), .cfg_base_i(cfg_base_i),
        .cfg_qsize_i(cfg_qsize_i), .cfg_irq_en_i(cfg_irq_en_i),
        .rec_valid_i(rec_valid_i), .rec_ready_o(rec_ready_o), .rec_cid_i(rec_cid_i),
        .rec_sqid_i(rec_sqid_i), .rec_sqhd_i(rec_sqhd_i), .rec_code_i(rec_code_i),
        .head_wr_i(head_wr_i), .head_val_i(head_val_i), .wr_valid_o(wr_valid_o),
        .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .irq_o(irq_o)
    );

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [127:0]      data;
    } exp_t;

    exp_t        exp_q[$];
    int          checks = 0;
    int          fails = 0;
    int          irq_cnt = 0;
    int          post_idx = 0;
    int          ring_size = 1;
    logic [63:0] ring_base = '0;
    bit          done = 1'b0;

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare every accepted write with the scoreboard front
    always @(negedge clk) begin
        if (irq_o) irq_cnt++;
        if (rst_n && wr_valid_o && wr_ready_i) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected write", wr_data_o, 128'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(wr_addr_o == e.addr, "R2 address", 128'(wr_addr_o), 128'(e.addr));
                chk(wr_data_o == e.data, "R3/R4 entry", wr_data_o, e.data);
            end
        end
    end

    task automatic create(input logic [63:0] base, input int size, input bit ien);
        @(negedge clk);
        create_i     = 1'b1;
        cfg_base_i   = base;
        cfg_qsize_i  = 16'(size - 1);
        cfg_irq_en_i = ien;
        @(negedge clk);
        create_i  = 1'b0;
        ring_base = base;
        ring_size = size;
        post_idx  = 0;
    endtask

    // driver: send one record, predict its entry from the requirements
    task automatic send(input logic [15:0] cid, input logic [15:0] sqid,
                        input logic [15:0] sqhd, input logic [14:0] code);
        exp_t e;
        int   slot;
        bit   ph;
        @(negedge clk);
        while (!rec_ready_o) @(negedge clk);
        rec_valid_i = 1'b1;
        rec_cid_i = cid; rec_sqid_i = sqid; rec_sqhd_i = sqhd; rec_code_i = code;
        slot = post_idx % ring_size;
        ph   = ((post_idx / ring_size) % 2) == 0;
        e.addr = ring_base + (64'(slot) << EXP);
        e.data = {code, ph, cid, sqid, sqhd, 64'h0};
        exp_q.push_back(e);
        post_idx++;
        @(negedge clk);
        rec_valid_i = 1'b0;
    endtask

    task automatic set_head(input logic [15:0] v);
        @(negedge clk);
        head_wr_i = 1'b1; head_val_i = v;
        @(negedge clk);
        head_wr_i = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 100 && exp_q.size() != 0; i++) @(negedge clk);
        chk(exp_q.size() == 0, "R5 drain", 128'(exp_q.size()), 128'h0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int irq_before;
        logic [ADDR_W-1:0] held_addr;
        repeat (3) @(negedge clk);
        chk(wr_valid_o == 1'b0, "R1 reset wr_valid", 128'(wr_valid_o), 128'h0);
        chk(irq_o == 1'b0, "R1 reset irq", 128'(irq_o), 128'h0);
        chk(rec_ready_o == 1'b1, "R1 reset rec_ready", 128'(rec_ready_o), 128'h1);
        rst_n = 1'b1;

        // ring of 4 entries, interrupts on
        create(64'h1000, 4, 1'b1);
        send(16'h0011, 16'd3, 16'd7, 15'h0000);
        send(16'h0012, 16'd3, 16'd8, 15'h0002);
        send(16'h0013, 16'd5, 16'd1, 15'h7fff);
        drain();
        chk(irq_cnt > 0, "R9 irq when enabled", 128'(irq_cnt), 128'h1);
        // ring now full: tail 3, head 0
        send(16'h0014, 16'd3, 16'd9, 15'h0001);
        repeat (10) @(negedge clk);
        chk(wr_valid_o == 1'b0, "R5 stall while full", 128'(wr_valid_o), 128'h0);
        chk(exp_q.size() == 1, "R5 record kept", 128'(exp_q.size()), 128'h1);
        send(16'h0015, 16'd4, 16'd2, 15'h0004);
        chk(rec_ready_o == 1'b0, "R7 backpressure", 128'(rec_ready_o), 128'h0);
        set_head(16'd9);
        repeat (8) @(negedge clk);
        chk(wr_valid_o == 1'b0, "R6 out-of-range head ignored", 128'(wr_valid_o), 128'h0);
        @(negedge clk);
        head_wr_i = 1'b1; head_val_i = 16'd2;
        @(negedge clk);
        head_wr_i = 1'b0;
        @(negedge clk);
        chk(wr_valid_o == 1'b1, "R6 head effect next cycle", 128'(wr_valid_o), 128'h1);
        drain();
        chk(rec_ready_o == 1'b1, "R7 ready after drain", 128'(rec_ready_o), 128'h1);
        send(16'h0016, 16'd1, 16'd0, 15'h0010);
        set_head(16'd1);
        drain();

        // ring of 2 entries, interrupts off, new base
        irq_before = irq_cnt;
        create(64'h8000, 2, 1'b0);
        send(16'h0021, 16'd2, 16'd4, 15'h0003);
        send(16'h0022, 16'd2, 16'd5, 15'h0006);
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 1, "R5 two-slot ring full", 128'(exp_q.size()), 128'h1);
        set_head(16'd1);
        drain();
        set_head(16'd0);
        wr_ready_i = 1'b0;
        send(16'h0023, 16'd2, 16'd6, 15'h0009);
        repeat (3) @(negedge clk);
        held_addr = wr_addr_o;
        repeat (4) @(negedge clk);
        chk(wr_valid_o == 1'b1, "R8 request held", 128'(wr_valid_o), 128'h1);
        chk(wr_addr_o == held_addr, "R8 address stable", 128'(wr_addr_o), 128'(held_addr));
        wr_ready_i = 1'b1;
        drain();
        chk(irq_cnt == irq_before, "R9 no irq when disabled", 128'(irq_cnt), 128'(irq_before));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule